// File: doc/BRIEF.md
# Page-Mode Pseudo-Static Memory Read Controller

This block sits on the synchronous side of a chip and reads from an external 1M x 16 asynchronous pseudo-static memory. A host places a start address, a word count and two byte-lane enables on a one-cycle request port. The block then drives chip select, output enable, write enable, the two byte-lane strobes and the 20-bit address. It waits a number of clock cycles derived from the memory's access times, captures the 16-bit data, and returns each word with a one-cycle valid strobe.

A burst stays inside one four-word page, so only address bits 1:0 move during it. When the page-read configuration input is set, every word after the first uses the short page access time. When it is clear, every word waits the full random access time. The memory hides its refresh behind chip-select high time, so the block never holds chip select low past a configurable ceiling. If the next word would break that ceiling, it lifts chip select, waits the recovery time and starts that word again as a random read. All timings are parameters in picoseconds and are rounded up to whole clock cycles.

Top module: `psram_page_rd`

## Requirements
- R1: While reset is asserted and right after it is released, chip select, output enable, write enable and both byte strobes are high, `req_ready_o` is high and `rsp_valid_o` is low. An asynchronous reset in the middle of an access lifts chip select at once.
- R2: A request is accepted only on a cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only when the block is idle, and `req_valid_i` while busy produces no access and no response.
- R3: The first word of every request appears on `rsp_valid_o` exactly ceil(T_AA_PS/CLK_PS) cycles after the accepting clock edge (9 cycles at the defaults).
- R4: With the page-read input high when the request is accepted, each further word follows the previous one by ceil(T_PAA_PS/CLK_PS) cycles (4 at the defaults). Chip select stays low between these words.
- R5: With the page-read input low when the request is accepted, each further word follows the previous one by the full random access count. Word i is read from start address + i.
- R6: The effective word count is min(len, 4 - addr[1:0]). A `req_len_i` of 0, or a count past the page end, is cut at the page end, and `rsp_err_o` is then high on every word of that request. For an in-range count it is low.
- R7: `rsp_last_o` is high on the final word of a request only.
- R8: During an access the low-byte strobe is low only if `req_be_i[0]` was 1, and the high-byte strobe is low only if `req_be_i[1]` was 1. Output enable is low. Data bits of a disabled lane return as zero.
- R9: Chip select is never low for more than ceil(T_CEM_PS/CLK_PS) cycles. When the next word would exceed that limit, chip select rises for the recovery time. That word is then reissued and arrives a full random access count after chip select falls again.
- R10: Each high interval of chip select between accesses lasts at least ceil(T_CEH_PS/CLK_PS) cycles.
- R11: Write enable stays high at all times.
- R12: While chip select is low, any address value is held for at least ceil(T_ADDR_MIN_PS/CLK_PS) cycles before it changes.
- R13: While chip select stays low, address bits 19:2 do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_en_i | input | 1 | Page-read enable, sampled when a request is accepted |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 20 | Start word address |
| req_len_i | input | 3 | Word count 1..4; 0 means read to page end |
| req_be_i | input | 2 | Byte lanes: bit 0 low byte, bit 1 high byte |
| req_ready_o | output | 1 | Block is idle and will take a request |
| rsp_valid_o | output | 1 | Read word valid |
| rsp_data_o | output | 16 | Read word, disabled lanes zeroed |
| rsp_last_o | output | 1 | Final word of the request |
| rsp_err_o | output | 1 | Request count was truncated |
| mem_ce_no | output | 1 | Memory chip select, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_lb_no | output | 1 | Low byte strobe, active low |
| mem_hb_no | output | 1 | High byte strobe, active low |
| mem_addr_o | output | 20 | Memory word address |
| mem_data_i | input | 16 | Memory read data |

## Verification
Assertions check the memory-side safety rules on every cycle. These are the chip-select ceiling, the minimum high time of chip select, the minimum address hold while selected, the frozen upper address bits, idle-only readiness and the single last strobe. Only the bench scenarios can show that the cycle counts of the first and later words are correct. The same holds for the split-and-reissue arrival time, truncation and its error flag, lane masking of the returned data, and the address each word came from.

// File: rtl/prd_pkg.sv
package prd_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_RECOV} prd_state_e;

  // round a picosecond limit up to whole clock cycles, never below one
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/prd_req_shape.sv
module prd_req_shape #(
  parameter int unsigned PG_W = 2
) (
  input  logic [PG_W-1:0] col_i,
  input  logic [PG_W:0]   len_i,
  output logic [PG_W:0]   len_o,
  output logic            trunc_o
);
  localparam int unsigned LEN_W    = PG_W + 1;
  localparam int unsigned PG_WORDS = 1 << PG_W;

  logic [LEN_W-1:0] room;

  always_comb begin
    room = LEN_W'(PG_WORDS) - {1'b0, col_i};
    if (len_i == '0 || len_i > room) begin
      len_o   = room;
      trunc_o = 1'b1;
    end else begin
      len_o   = len_i;
      trunc_o = 1'b0;
    end
  end

endmodule

// File: rtl/prd_wait_timer.sv
module prd_wait_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == CNT_W'(1));

  // R3: a zero wait would never expire
  p_load_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> load_val_i != '0);

endmodule

// File: rtl/prd_ce_budget.sv
module prd_ce_budget #(
  parameter int unsigned LIMIT  = 1250,
  parameter int unsigned WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              low_i,
  input  logic [WAIT_W-1:0] next_wait_i,
  output logic              fits_o
);
  localparam int unsigned RUN_W = $clog2(LIMIT + 1);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             run_q <= '0;
    else if (launch_i)                       run_q <= '0;
    else if (low_i && run_q != RUN_W'(LIMIT)) run_q <= run_q + 1'b1;
  end

  // select stays low until the edge that ends the next wait
  assign fits_o = (32'(run_q) + 32'd1 + 32'(next_wait_i)) <= LIMIT;

  p_ce_limit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_i |-> 32'(run_q) < LIMIT);

endmodule

// File: rtl/psram_page_rd.sv
module psram_page_rd
  import prd_pkg::*;
#(
  parameter int unsigned ADDR_W        = 20,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CLK_PS        = 8000,
  parameter int unsigned T_AA_PS       = 70000,
  parameter int unsigned T_PAA_PS      = 25000,
  parameter int unsigned T_CEH_PS      = 10000,
  parameter int unsigned T_CEM_PS      = 10000000,
  parameter int unsigned T_ADDR_MIN_PS = 30000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_en_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_len_i,
  input  logic [1:0]        req_be_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_last_o,
  output logic              rsp_err_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_lb_no,
  output logic              mem_hb_no,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam int unsigned PG_W    = 2;
  localparam int unsigned LEN_W   = PG_W + 1;
  localparam int unsigned LANE_W  = DATA_W / 2;
  localparam int unsigned AA_CYC  = ps_to_cyc(T_AA_PS, CLK_PS);
  localparam int unsigned PAA_CYC = ps_to_cyc(T_PAA_PS, CLK_PS);
  localparam int unsigned CEH_CYC = ps_to_cyc(T_CEH_PS, CLK_PS);
  localparam int unsigned CEM_CYC = ps_to_cyc(T_CEM_PS, CLK_PS);
  localparam int unsigned GAP_CYC = ps_to_cyc(T_ADDR_MIN_PS, CLK_PS);
  localparam int unsigned TMAX_A  = (AA_CYC > CEH_CYC) ? AA_CYC : CEH_CYC;
  localparam int unsigned TMAX    = (TMAX_A > PAA_CYC) ? TMAX_A : PAA_CYC;
  localparam int unsigned TW      = $clog2(TMAX + 1);

  prd_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic              err_q, page_q, ce_nq;
  logic [1:0]        be_q;
  logic              rsp_valid_q, rsp_last_q, rsp_err_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [LEN_W-1:0]  shaped_len;
  logic              shaped_err;
  logic              tmr_load, tmr_done, launch, fits, accept;
  logic [TW-1:0]     tmr_val, next_wait;
  logic [DATA_W-1:0] lane_mask;

  prd_req_shape #(.PG_W(PG_W)) u_shape (
    .col_i   (req_addr_i[PG_W-1:0]),
    .len_i   (req_len_i),
    .len_o   (shaped_len),
    .trunc_o (shaped_err)
  );

  prd_wait_timer #(.CNT_W(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  prd_ce_budget #(.LIMIT(CEM_CYC), .WAIT_W(TW)) u_budget (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .low_i       (!ce_nq),
    .next_wait_i (next_wait),
    .fits_o      (fits)
  );

  assign accept    = req_valid_i && (st_q == ST_IDLE);
  assign next_wait = page_q ? TW'(PAA_CYC) : TW'(AA_CYC);
  assign lane_mask = {{LANE_W{be_q[1]}}, {LANE_W{be_q[0]}}};

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(AA_CYC);
    launch   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        launch   = 1'b1;
      end
      ST_ACCESS: if (tmr_done) begin
        tmr_load = 1'b1;
        if (left_q == LEN_W'(1) || !fits) tmr_val = TW'(CEH_CYC);
        else                              tmr_val = next_wait;
      end
      ST_RECOV: if (tmr_done && left_q != '0) begin
        tmr_load = 1'b1;
        launch   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      left_q      <= '0;
      err_q       <= 1'b0;
      page_q      <= 1'b0;
      be_q        <= '0;
      ce_nq       <= 1'b1;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_last_q  <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          addr_q <= req_addr_i;
          left_q <= shaped_len;
          err_q  <= shaped_err;
          page_q <= page_en_i;
          be_q   <= req_be_i;
          ce_nq  <= 1'b0;
          st_q   <= ST_ACCESS;
        end
        ST_ACCESS: if (tmr_done) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= mem_data_i & lane_mask;
          rsp_last_q  <= (left_q == LEN_W'(1));
          rsp_err_q   <= err_q;
          left_q      <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) begin
            ce_nq <= 1'b1;
            st_q  <= ST_RECOV;
          end else begin
            addr_q[PG_W-1:0] <= addr_q[PG_W-1:0] + 1'b1;
            if (!fits) begin
              // select ceiling reached: release and reissue remaining words
              ce_nq <= 1'b1;
              st_q  <= ST_RECOV;
            end
          end
        end
        ST_RECOV: if (tmr_done) begin
          if (left_q != '0) begin
            ce_nq <= 1'b0;
            st_q  <= ST_ACCESS;
          end else begin
            st_q  <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign rsp_last_o  = rsp_last_q;
  assign rsp_err_o   = rsp_err_q;
  assign mem_ce_no   = ce_nq;
  assign mem_oe_no   = ce_nq;
  assign mem_we_no   = 1'b1;
  assign mem_lb_no   = ce_nq | ~be_q[0];
  assign mem_hb_no   = ce_nq | ~be_q[1];
  assign mem_addr_o  = addr_q;

  // checker state for memory-side timing rules
  localparam int unsigned HOLD_W = $clog2(GAP_CYC + 1);
  localparam int unsigned HIGH_W = $clog2(CEH_CYC + 1);
  logic [ADDR_W-1:0] chk_prev_addr_q;
  logic [HOLD_W-1:0] chk_hold_q;
  logic [HIGH_W-1:0] chk_high_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_prev_addr_q <= '0;
      chk_hold_q      <= HOLD_W'(GAP_CYC);
      chk_high_q      <= HIGH_W'(CEH_CYC);
    end else begin
      chk_prev_addr_q <= mem_addr_o;
      if (mem_addr_o != chk_prev_addr_q)        chk_hold_q <= HOLD_W'(1);
      else if (chk_hold_q != HOLD_W'(GAP_CYC))  chk_hold_q <= chk_hold_q + 1'b1;
      if (!mem_ce_no)                           chk_high_q <= '0;
      else if (chk_high_q != HIGH_W'(CEH_CYC))  chk_high_q <= chk_high_q + 1'b1;
    end
  end

  p_ready_ce_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_ce_no);

  p_last_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_last_o) |=> !rsp_valid_o);

  p_ceh_min_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_no) |-> 32'(chk_high_q) >= CEH_CYC);

  p_addr_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no) && mem_addr_o != $past(mem_addr_o))
      |-> 32'(chk_hold_q) >= GAP_CYC);

  p_upper_stable_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o[ADDR_W-1:PG_W]));

endmodule

// File: tb/psram_page_rd_test.sv
module psram_page_rd_test;
  localparam int AA = 9, PAA = 4, CEH = 2, CEM = 25, GAP = 4;

  typedef struct packed {
    logic        page;
    logic [19:0] addr;
    logic [2:0]  len;
    logic [1:0]  be;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 20'h12340, 3'd4, 2'b11},
    '{1'b1, 20'hABCD2, 3'd2, 2'b11},
    '{1'b1, 20'h00003, 3'd1, 2'b01},
    '{1'b1, 20'h55551, 3'd4, 2'b10},
    '{1'b1, 20'hFFFFE, 3'd0, 2'b11},
    '{1'b0, 20'h0F0F0, 3'd4, 2'b11},
    '{1'b0, 20'h33332, 3'd2, 2'b01},
    '{1'b1, 20'h80000, 3'd7, 2'b00}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic page_en_i = 1'b0, req_valid_i = 1'b0;
  logic [19:0] req_addr_i = '0;
  logic [2:0]  req_len_i = '0;
  logic [1:0]  req_be_i = '0;
  logic req_ready_o, rsp_valid_o, rsp_last_o, rsp_err_o;
  logic [15:0] rsp_data_o;
  logic mem_ce_no, mem_oe_no, mem_we_no, mem_lb_no, mem_hb_no;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_data_i;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] model(input logic [19:0] a);
    return {a[7:0], a[15:8] ^ {4'h0, a[19:16]}} ^ 16'hC35A;
  endfunction

  assign mem_data_i = model(mem_addr_o);

  psram_page_rd #(.T_CEM_PS(200000)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .page_en_i(page_en_i),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_len_i(req_len_i),
    .req_be_i(req_be_i), .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
    .rsp_data_o(rsp_data_o), .rsp_last_o(rsp_last_o), .rsp_err_o(rsp_err_o),
    .mem_ce_no(mem_ce_no), .mem_oe_no(mem_oe_no), .mem_we_no(mem_we_no),
    .mem_lb_no(mem_lb_no), .mem_hb_no(mem_hb_no), .mem_addr_o(mem_addr_o),
    .mem_data_i(mem_data_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory-side monitors
  int low_run = 0, high_run = 0, max_low = 0, min_high = 1000;
  int we_low = 0, hold = 100, hold_viol = 0, upper_viol = 0;
  logic [19:0] prev_addr = '0;
  logic prev_ce_n = 1'b1;

  always @(negedge clk) begin
    if (!rst_ni) begin
      low_run = 0; high_run = 100; hold = 100; prev_ce_n = 1'b1;
    end else begin
      if (!mem_we_no) we_low++;
      if (!mem_ce_no) begin
        if (prev_ce_n && high_run < min_high) min_high = high_run;
        low_run++; high_run = 0;
        if (low_run > max_low) max_low = low_run;
        if (!prev_ce_n && mem_addr_o != prev_addr) begin
          if (hold < GAP) hold_viol++;
          if (mem_addr_o[19:2] != prev_addr[19:2]) upper_viol++;
        end
      end else begin
        low_run = 0; high_run++;
      end
      if (mem_addr_o != prev_addr) hold = 1; else hold++;
      prev_addr = mem_addr_o;
      prev_ce_n = mem_ce_no;
    end
  end

  task automatic run_vec(input vec_t v);
    int exp_n, t, run, w, cyc, got, room;
    bit exp_err;
    int arr[4];
    bit split[4];
    logic [15:0] mask, ed;
    room = 4 - int'(v.addr[1:0]);
    if (v.len == 0 || int'(v.len) > room) begin exp_n = room; exp_err = 1; end
    else begin exp_n = int'(v.len); exp_err = 0; end
    t = 0; run = 0;
    for (int i = 0; i < exp_n; i++) begin
      w = (i == 0) ? AA : (v.page ? PAA : AA);
      split[i] = 0;
      if (i > 0 && run + w > CEM) begin t += CEH; run = 0; w = AA; split[i] = 1; end
      t += w; run += w; arr[i] = t;
    end
    mask = {{8{v.be[1]}}, {8{v.be[0]}}};
    while (!req_ready_o) @(negedge clk);
    page_en_i = v.page; req_addr_i = v.addr; req_len_i = v.len; req_be_i = v.be;
    req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    page_en_i = ~v.page;
    cyc = 0; got = 0;
    while (cyc < 120) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc == 1) begin
        chk(mem_lb_no == ~v.be[0] && mem_hb_no == ~v.be[1], "R8 lanes",
            {mem_hb_no, mem_lb_no}, {~v.be[1], ~v.be[0]});
        chk(mem_oe_no == 0 && mem_ce_no == 0, "R8 oe", {mem_ce_no, mem_oe_no}, 0);
      end
      if (cyc >= 2 && cyc <= 4) begin req_valid_i = 1'b1; req_addr_i = 20'hDEAD0; req_len_i = 3'd4; end
      if (cyc == 5) req_valid_i = 1'b0;
      if (rsp_valid_o) begin
        if (got < exp_n) begin
          ed = model(v.addr + 20'(got)) & mask;
          chk(rsp_data_o == ed, "R8 data/R5 addr", rsp_data_o, ed);
          chk(rsp_err_o == exp_err, "R6", rsp_err_o, exp_err);
          chk(rsp_last_o == (got == exp_n - 1), "R7", rsp_last_o, got == exp_n - 1);
          if (got == 0)         chk(cyc == arr[got], "R3", cyc, arr[got]);
          else if (split[got])  chk(cyc == arr[got], "R9", cyc, arr[got]);
          else if (v.page)      chk(cyc == arr[got], "R4", cyc, arr[got]);
          else                  chk(cyc == arr[got], "R5", cyc, arr[got]);
        end
        got++;
      end
    end
    chk(got == exp_n, "R2/R6 count", got, exp_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_no && mem_oe_no && mem_we_no && mem_lb_no && mem_hb_no, "R1 in reset",
        {mem_ce_no, mem_oe_no, mem_we_no, mem_lb_no, mem_hb_no}, 5'h1f);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1 && rsp_valid_o == 0, "R1 after reset", {req_ready_o, rsp_valid_o}, 2'b10);
    chk(mem_ce_no == 1, "R1 ce", mem_ce_no, 1);

    for (int i = 0; i < 8; i++) run_vec(VEC[i]);

    // reset in the middle of an access
    while (!req_ready_o) @(negedge clk);
    page_en_i = 1'b1; req_addr_i = 20'h44440; req_len_i = 3'd4; req_be_i = 2'b11;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    repeat (5) @(negedge clk);
    chk(mem_ce_no == 0, "R1 busy before reset", mem_ce_no, 0);
    #1 rst_ni = 1'b0;
    #1 chk(mem_ce_no == 1 && mem_oe_no == 1, "R1 async reset", {mem_ce_no, mem_oe_no}, 2'b11);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1 && rsp_valid_o == 0, "R1 ready after mid reset", req_ready_o, 1);
    repeat (20) @(negedge clk);
    chk(rsp_valid_o == 0 && mem_ce_no == 1, "R2 no stray after reset", rsp_valid_o, 0);

    run_vec(VEC[5]);

    chk(max_low <= CEM, "R9 ce low max", max_low, CEM);
    chk(min_high >= CEH, "R10 ce high min", min_high, CEH);
    chk(we_low == 0, "R11 we high", we_low, 0);
    chk(hold_viol == 0, "R12 addr hold", hold_viol, 0);
    chk(upper_viol == 0, "R13 upper addr", upper_viol, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule